// File: doc/BRIEF.md
# Four-Register Interleaving Store Sequencer

This block turns one structure-store operation into a stream of single-element memory writes. It receives four 64-bit vector registers, an element size, a base address, an alignment requirement and a writeback selector. It then writes the registers out as interleaved four-element structures. For each element index, taken in ascending order, it writes that element from register 0, then register 1, then register 2, then register 3, into adjacent slots. Whatever the element size, 32 bytes are written in total.

The alignment of the base address is checked before anything is written. A failed check, or an illegal size code, ends the operation at once with an error flag. No write is made and no writeback occurs. When the last write beat has been accepted, the block reports completion. At that point it also offers the updated base register value, which is either unchanged, stepped by 32, or stepped by a supplied register value. The surrounding pipeline owns the register file and the condition flags, and the block touches neither.

Top module: `quad_interleave_store`

## Requirements
- R1: `accept_o` is high only while the block is idle. An operation starts on a clock edge where `start_i` and `accept_o` are both high. A `start_i` pulse while busy has no effect on the writes in progress.
- R2: Size code `size_i` 00, 01 and 10 selects 8-, 16- and 32-bit elements. Every write beat shows that code on `wr_size_o` and carries its element zero-extended in the low bits of `wr_data_o`.
- R3: For legal operations the block issues exactly 32/bytes-per-element beats. Beat k carries element k/4 of register k mod 4, where register j occupies `regs_i[64j+63:64j]` and element e occupies bits [e·w+w-1 : e·w] of its register, w being the element width in bits. Beat k is written to address base + k·bytes-per-element (little-endian slots).
- R4: While `wr_valid_o` is high and `wr_ready_i` is low, the address, data and size of the request stay unchanged in the next cycle.
- R5: Alignment code `align_i` 00, 01, 10 and 11 requires 1-, 8-, 16- and 32-byte alignment of `base_i`. A misaligned base raises `fault_o` together with `done_o` in the cycle after acceptance. It issues no beat, and `wb_en_o` stays low.
- R6: Size code 11 raises `undef_o` together with `done_o` in the cycle after acceptance. It issues no beat and no writeback. This takes precedence over the alignment check, so `fault_o` stays low.
- R7: For a legal operation, `done_o` is high for exactly one cycle, in the cycle right after the last beat was accepted.
- R8: Writeback is offered only with `done_o`, on successful operations. Selector 15 gives `wb_en_o` low. Selector 13 gives `wb_val_o` = base + 32. Any other selector gives `wb_val_o` = base + `idx_val_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Operation request |
| accept_o | output | 1 | Idle; request taken this edge if start_i high |
| regs_i | input | 256 | Four source registers, register j in bits [64j+63:64j] |
| size_i | input | 2 | Element size code |
| base_i | input | 32 | Base address |
| align_i | input | 2 | Alignment requirement code |
| idx_sel_i | input | 4 | Writeback selector |
| idx_val_i | input | 32 | Step value for register-supplied writeback |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | 32 | Byte address of the beat |
| wr_data_o | output | 32 | Element, zero-extended |
| wr_size_o | output | 2 | Size code of the beat |
| done_o | output | 1 | Operation complete (one cycle) |
| fault_o | output | 1 | Alignment fault, valid with done_o |
| undef_o | output | 1 | Illegal size code, valid with done_o |
| wb_en_o | output | 1 | Base writeback enable, valid with done_o |
| wb_val_o | output | 32 | Updated base value |

## Verification
The assertions assume that `wr_ready_i` is only meaningful while a beat is offered. They also assume that the memory side never withdraws a beat once it has been accepted. The address-step property further assumes that two operations are never back-to-back without an idle cycle, which the completion cycle guarantees. The stimulus drives every input on the falling edge. It varies the ready pattern between always-ready and periodic stalls. It keeps operands steady from the request until acceptance, and it changes them only while the block is busy, to show that they are ignored.

// File: rtl/qis_pkg.sv
package qis_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_DONE
  } qis_state_e;

  localparam logic [1:0] SZ_ILLEGAL = 2'b11;
  localparam logic [3:0] IDX_NO_WB  = 4'd15;
  localparam logic [3:0] IDX_STEP32 = 4'd13;
endpackage

// File: rtl/qis_align_chk.sv
module qis_align_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        align_i,
  output logic              ok_o
);
  logic [4:0] mask;

  // code 0 -> 1 byte, code n -> 2^(n+2) bytes
  always_comb begin
    if (align_i == 2'd0) mask = 5'd0;
    else                 mask = 5'((6'd1 << (3'(align_i) + 3'd2)) - 6'd1);
  end

  assign ok_o = (addr_i[4:0] & mask) == 5'd0;
endmodule

// File: rtl/qis_beat_ctr.sv
module qis_beat_ctr #(
  parameter int unsigned TOTAL_BYTES = 32,
  localparam int unsigned BEAT_W     = $clog2(TOTAL_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [1:0]        size_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W:0]   n_beats;

  assign n_beats = (BEAT_W+1)'(TOTAL_BYTES) >> size_i;
  assign last_o  = ({1'b0, beat_q} == n_beats - 1'b1);
  assign beat_o  = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (clr_i)  beat_q <= '0;
    else if (adv_i)  beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/qis_elem_sel.sv
module qis_elem_sel #(
  parameter int unsigned VREG_W = 64,
  parameter int unsigned NREG   = 4,
  parameter int unsigned BEAT_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [NREG*VREG_W-1:0] regs_i,
  input  logic [BEAT_W-1:0]      beat_i,
  input  logic [1:0]             size_i,
  output logic [DATA_W-1:0]      data_o
);
  localparam int unsigned RSEL_W = $clog2(NREG);
  localparam int unsigned SH_W   = $clog2(VREG_W);

  logic [VREG_W-1:0] lane [NREG];
  logic [VREG_W-1:0] sel, shifted;
  logic [BEAT_W-1:0] elem;
  logic [SH_W-1:0]   sh;

  for (genvar g = 0; g < NREG; g++) begin : g_lane
    assign lane[g] = regs_i[g*VREG_W +: VREG_W];
  end

  assign sel     = lane[beat_i[RSEL_W-1:0]];
  assign elem    = beat_i >> RSEL_W;
  assign sh      = SH_W'((32'(elem) * 8) << size_i);
  assign shifted = sel >> sh;

  always_comb begin
    case (size_i)
      2'd0:    data_o = DATA_W'(shifted[7:0]);
      2'd1:    data_o = DATA_W'(shifted[15:0]);
      default: data_o = DATA_W'(shifted[31:0]);
    endcase
  end
endmodule

// File: rtl/quad_interleave_store.sv
module quad_interleave_store
  import qis_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VREG_W = 64,
  parameter int unsigned NREG   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  output logic                   accept_o,
  input  logic [NREG*VREG_W-1:0] regs_i,
  input  logic [1:0]             size_i,
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [1:0]             align_i,
  input  logic [3:0]             idx_sel_i,
  input  logic [ADDR_W-1:0]      idx_val_i,
  output logic                   wr_valid_o,
  input  logic                   wr_ready_i,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [31:0]            wr_data_o,
  output logic [1:0]             wr_size_o,
  output logic                   done_o,
  output logic                   fault_o,
  output logic                   undef_o,
  output logic                   wb_en_o,
  output logic [ADDR_W-1:0]      wb_val_o
);
  localparam int unsigned TOTAL_BYTES = NREG * VREG_W / 8;
  localparam int unsigned BEAT_W      = $clog2(TOTAL_BYTES);

  qis_state_e              state_q;
  logic [NREG*VREG_W-1:0]  regs_q;
  logic [ADDR_W-1:0]       base_q, idx_val_q;
  logic [1:0]              size_q;
  logic [3:0]              idx_sel_q;
  logic                    fault_q, undef_q;
  logic                    take, align_ok, bad_size, adv, last;
  logic [BEAT_W-1:0]       beat;

  assign accept_o = (state_q == ST_IDLE);
  assign take     = start_i && accept_o;
  assign bad_size = (size_i == SZ_ILLEGAL);
  assign adv      = (state_q == ST_BUSY) && wr_ready_i;

  qis_align_chk #(.ADDR_W(ADDR_W)) i_align (
    .addr_i (base_i),
    .align_i(align_i),
    .ok_o   (align_ok)
  );

  qis_beat_ctr #(.TOTAL_BYTES(TOTAL_BYTES)) i_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (take),
    .adv_i (adv),
    .size_i(size_q),
    .beat_o(beat),
    .last_o(last)
  );

  qis_elem_sel #(
    .VREG_W(VREG_W),
    .NREG  (NREG),
    .BEAT_W(BEAT_W),
    .DATA_W(32)
  ) i_sel (
    .regs_i(regs_q),
    .beat_i(beat),
    .size_i(size_q),
    .data_o(wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      regs_q    <= '0;
      base_q    <= '0;
      idx_val_q <= '0;
      size_q    <= '0;
      idx_sel_q <= IDX_NO_WB;
      fault_q   <= 1'b0;
      undef_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          regs_q    <= regs_i;
          base_q    <= base_i;
          idx_val_q <= idx_val_i;
          size_q    <= size_i;
          idx_sel_q <= idx_sel_i;
          undef_q   <= bad_size;
          // illegal size wins over alignment
          fault_q   <= !bad_size && !align_ok;
          state_q   <= (bad_size || !align_ok) ? ST_DONE : ST_BUSY;
        end
        ST_BUSY: if (adv && last) state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid_o = (state_q == ST_BUSY);
  assign wr_addr_o  = base_q + (ADDR_W'(beat) << size_q);
  assign wr_size_o  = size_q;
  assign done_o     = (state_q == ST_DONE);
  assign fault_o    = done_o && fault_q;
  assign undef_o    = done_o && undef_q;
  assign wb_en_o    = done_o && !fault_q && !undef_q && (idx_sel_q != IDX_NO_WB);

  always_comb begin
    if (idx_sel_q == IDX_NO_WB)       wb_val_o = base_q;
    else if (idx_sel_q == IDX_STEP32) wb_val_o = base_q + ADDR_W'(TOTAL_BYTES);
    else                              wb_val_o = base_q + idx_val_q;
  end
endmodule

// File: rtl/quad_interleave_store_chk.sv
module quad_interleave_store_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              accept_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [31:0]       wr_data_o,
  input logic [1:0]        wr_size_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              undef_o,
  input logic              wb_en_o
);
  // R1
  idle_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o || done_o) |-> !accept_o);

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)
                                     && $stable(wr_data_o) && $stable(wr_size_o)));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i) |=>
      (!wr_valid_o || wr_addr_o == $past(wr_addr_o) + (ADDR_W'(1) << wr_size_o)));

  // R5
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o || undef_o) |-> (done_o && !wb_en_o && !wr_valid_o));

  // R6
  undef_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !fault_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && !undef_o) |-> $past(wr_valid_o && wr_ready_i));

  // R8
  wb_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);
endmodule

bind quad_interleave_store quad_interleave_store_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_quad_interleave_store.sv
module test_quad_interleave_store;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         accept_o;
  logic [255:0] regs_i = '0;
  logic [1:0]   size_i = '0;
  logic [31:0]  base_i = '0;
  logic [1:0]   align_i = '0;
  logic [3:0]   idx_sel_i = 4'd15;
  logic [31:0]  idx_val_i = '0;
  logic         wr_valid_o;
  logic         wr_ready_i = 1'b0;
  logic [31:0]  wr_addr_o;
  logic [31:0]  wr_data_o;
  logic [1:0]   wr_size_o;
  logic         done_o, fault_o, undef_o, wb_en_o;
  logic [31:0]  wb_val_o;

  int tests = 0;
  int fails = 0;
  int wd    = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  quad_interleave_store i_quad_interleave_store (.*);

  always @(posedge clk_i) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_elem(input logic [255:0] r, input logic [1:0] sz, input int k);
    int w = 8 << sz;
    logic [63:0] v = r[(k % 4)*64 +: 64];
    logic [63:0] s = v >> ((k / 4) * w);
    return (sz == 0) ? {24'h0, s[7:0]} : (sz == 1) ? {16'h0, s[15:0]} : s[31:0];
  endfunction

  // stall: 0 always ready, 1 every other cycle, 2 one in three
  task automatic run_op(input logic [255:0] r, input logic [1:0] sz, input logic [31:0] base,
                        input logic [1:0] al, input logic [3:0] ix, input logic [31:0] iv,
                        input int stall, input bit poke);
    logic [4:0]  mask  = (al == 0) ? 5'd0 : 5'((1 << (al + 2)) - 1);
    bit          e_und = (sz == 2'b11);
    bit          e_flt = !e_und && ((base[4:0] & mask) != 0);
    int          nb    = (e_und || e_flt) ? 0 : (32 >> sz);
    int          acc = 0, cyc = 0;
    bit          prev_acc = 0, prev_stall = 0, done = 0;
    logic [31:0] s_addr = '0, s_data = '0;
    @(negedge clk_i);
    regs_i = r; size_i = sz; base_i = base; align_i = al; idx_sel_i = ix; idx_val_i = iv;
    start_i = 1'b1;
    chk(accept_o === 1'b1, "R1 idle accept", 32'(accept_o), 1);
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done && cyc < 400) begin
      wr_ready_i = (stall == 0) ? 1'b1 : (stall == 1) ? 1'(cyc % 2) : 1'(cyc % 3 == 2);
      if (done_o) begin
        done = 1;
        chk(acc == nb, "R3 beat count", 32'(acc), 32'(nb));
        if (nb > 0) chk(prev_acc, "R7 done timing", 32'(prev_acc), 1);
        else        chk(cyc == 0, "R5/R6 early done", 32'(cyc), 0);
        chk(fault_o === e_flt, "R5 fault", 32'(fault_o), 32'(e_flt));
        chk(undef_o === e_und, "R6 undef", 32'(undef_o), 32'(e_und));
        chk(wb_en_o === (nb > 0 && ix != 15), "R8 wb enable", 32'(wb_en_o), 32'(nb > 0 && ix != 15));
        if (nb > 0 && ix != 15)
          chk(wb_val_o == ((ix == 13) ? base + 32 : base + iv), "R8 wb value", wb_val_o,
              (ix == 13) ? base + 32 : base + iv);
      end else begin
        if (poke && cyc == 2) begin
          start_i = 1'b1;
          regs_i  = ~r;
          chk(accept_o === 1'b0, "R1 busy reject", 32'(accept_o), 0);
        end else start_i = 1'b0;
        prev_acc = 0;
        if (wr_valid_o) begin
          if (prev_stall) begin
            chk(wr_addr_o == s_addr, "R4 addr hold", wr_addr_o, s_addr);
            chk(wr_data_o == s_data, "R4 data hold", wr_data_o, s_data);
          end
          chk(wr_addr_o == base + 32'(acc << sz), "R3 address", wr_addr_o, base + 32'(acc << sz));
          chk(wr_data_o == exp_elem(r, sz, acc), "R3 data", wr_data_o, exp_elem(r, sz, acc));
          chk(wr_size_o == sz, "R2 size", 32'(wr_size_o), 32'(sz));
          s_addr = wr_addr_o; s_data = wr_data_o;
          prev_stall = !wr_ready_i;
          if (wr_ready_i) begin acc++; prev_acc = 1; end
        end
        @(negedge clk_i);
        cyc++;
      end
    end
    chk(done, "R7 done seen", 32'(done), 1);
    wr_ready_i = 1'b0;
    start_i    = 1'b0;
    @(negedge clk_i);
    chk(done_o === 1'b0, "R7 single pulse", 32'(done_o), 0);
  endtask

  function automatic logic [255:0] pattern(input int seed);
    logic [255:0] p;
    for (int i = 0; i < 32; i++) p[i*8 +: 8] = 8'((i * 37 + seed * 11 + 5) ^ (i << 4));
    return p;
  endfunction

  task automatic t_reset();
    @(negedge clk_i);
    chk(accept_o === 1'b1, "R1 reset idle", 32'(accept_o), 1);
    chk(wr_valid_o === 1'b0, "R3 reset no beat", 32'(wr_valid_o), 0);
    chk(done_o === 1'b0, "R7 reset no done", 32'(done_o), 0);
  endtask

  task automatic t_bytes();   run_op(pattern(1), 2'd0, 32'h0000_1000, 2'd3, 4'd15, 32'h0, 0, 0); endtask
  task automatic t_halves();  run_op(pattern(2), 2'd1, 32'h0000_2008, 2'd1, 4'd13, 32'h0, 1, 0); endtask
  task automatic t_words();   run_op(pattern(3), 2'd2, 32'h0000_3010, 2'd2, 4'd3, 32'h0000_0100, 2, 1); endtask
  task automatic t_misalign(); run_op(pattern(4), 2'd2, 32'h0000_1008, 2'd2, 4'd13, 32'h0, 0, 0); endtask
  task automatic t_align_edge();
    run_op(pattern(5), 2'd0, 32'h0000_1003, 2'd0, 4'd7, 32'hFFFF_FFF0, 0, 0);
    run_op(pattern(6), 2'd1, 32'h0000_1004, 2'd1, 4'd13, 32'h0, 0, 0);
    run_op(pattern(7), 2'd2, 32'h0000_1020, 2'd3, 4'd13, 32'h0, 1, 0);
  endtask
  task automatic t_undef();   run_op(pattern(8), 2'd3, 32'h0000_1001, 2'd3, 4'd13, 32'h0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_bytes();
    t_halves();
    t_words();
    t_misalign();
    t_align_edge();
    t_undef();
    t_bytes();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule